// File: doc/BRIEF.md
# Distributed Shared-Bus Arbitration Node

Each processor on a shared external bus carries one copy of this block. No central arbiter exists: every node drives its own request line and watches the request lines of all the others, and each copy works out on its own which node owns the bus. Because every copy samples the same lines on the same clock edge and applies the same rule, all copies agree on the owner without any grant wire between them.

The core side raises an access request. The node then raises its bus request line, stalls the core until it owns the bus, and enables its bus drivers once it has won. When the core signals that its access sequence is complete, the node drops its line for one cycle. That cycle is the transition cycle: the bus is undriven, and the highest-priority waiting node takes ownership on the next edge. Priority is fixed by node ID, with ID 1 highest. When no node owns the bus, any request starts a fresh arbitration in the same way. After reset no node owns the bus, so node 1 wins if it requests.

Top module: `bus_arb_node`

## Requirements
- R1: `bus_req` rises in the same cycle as `acc_req`, combinationally, unless the node is in its one-cycle release after an access.
- R2: `stall` is high while `acc_req` is high and the node is not driving the bus. It is low in the first cycle of ownership.
- R3: The recorded owner changes only at an edge where no owner exists, or where the owner's sampled request line is low (a transition cycle). While the owner's line stays high, waiting nodes keep stalling.
- R4: When several lines are high at an arbitration edge, the lowest ID wins. Bit i of `req_lines` is the line of node ID i+1.
- R5: `drive_en` is high only while this node owns the bus and its own line is high. It is therefore low in the transition cycle.
- R6: Once the node owns the bus, `bus_req` stays high even if `acc_req` falls, until the cycle after `acc_done`. In that cycle `bus_req` is low for exactly one cycle.
- R7: While reset is active no node owns the bus, and `bus_req`, `drive_en` and `stall` are low when `acc_req` is low.
- R8: A node that is waiting keeps `bus_req` high until it has gained ownership and completed its access.
- R9: `node_id` ranges from 1 to NUM_NODES. The node's own bit of `req_lines` is ignored and replaced by its own `bus_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; lines are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | ID_W | Static node ID, 1..NUM_NODES |
| acc_req | input | 1 | Core needs an off-chip access |
| acc_done | input | 1 | Last cycle of the current access sequence |
| req_lines | input | NUM_NODES | Sampled request lines of all nodes |
| bus_req | output | 1 | This node's request line |
| stall | output | 1 | Holds the core until the node owns the bus |
| drive_en | output | 1 | Enables this node's bus drivers |

## Verification
`bus_req`, `stall` and `drive_en` are combinational from the inputs and the registered owner. A change of input therefore shows up in the same cycle, and a change of ownership shows up one edge after the cycle that decided it. The bench drives inputs just after a falling edge and checks one nanosecond later, so every check reads the state that the last rising edge settled. Each arbitration result is therefore checked in the cycle after the edge where the lines were sampled. The release cycle is checked in the cycle right after the one in which `acc_done` was driven.

// File: rtl/bus_arb_node.sv
module bus_arb_node #(
  parameter int NUM_NODES = 6,
  parameter int ID_W = $clog2(NUM_NODES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ID_W-1:0]      node_id,
  input  logic                 acc_req,
  input  logic                 acc_done,
  input  logic [NUM_NODES-1:0] req_lines,
  output logic                 bus_req,
  output logic                 stall,
  output logic                 drive_en
);

  logic [ID_W-1:0]      owner_q;
  logic                 hold_q;
  logic                 release_q;
  logic [NUM_NODES-1:0] lines;
  logic                 owner_line;
  logic                 open_arb;
  logic [ID_W-1:0]      winner;

  assign bus_req  = ~release_q & (hold_q | acc_req);
  assign drive_en = (owner_q == node_id) & bus_req;
  assign stall    = acc_req & ~drive_en;

  always_comb begin
    for (int i = 0; i < NUM_NODES; i++)
      lines[i] = (ID_W'(i + 1) == node_id) ? bus_req : req_lines[i];
  end

  always_comb begin
    owner_line = 1'b0;
    for (int i = 0; i < NUM_NODES; i++)
      if (ID_W'(i + 1) == owner_q) owner_line = lines[i];
  end

  assign open_arb = (owner_q == '0) | ~owner_line;

  always_comb begin
    winner = '0;
    for (int i = NUM_NODES - 1; i >= 0; i--)
      if (lines[i]) winner = ID_W'(i + 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q   <= '0;
      hold_q    <= 1'b0;
      release_q <= 1'b0;
    end else begin
      if (open_arb) owner_q <= winner;
      release_q <= drive_en & acc_done;
      hold_q    <= (drive_en & acc_done) ? 1'b0 : bus_req;
    end
  end

  AST_OWNER_ONLY_ON_TRANSITION: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q != '0 && owner_line) |=> $stable(owner_q)); // R3
  AST_RELEASE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && acc_done) |=> !bus_req); // R6
  AST_WAITER_KEEPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !drive_en && !acc_done) |=> (bus_req || $past(drive_en))); // R8
  AST_DRIVE_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> (bus_req && owner_q == node_id)); // R5
  AST_GRANT_NOT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en) |-> !stall); // R2

endmodule

// File: tb/bus_arb_node_tb_top.sv
`timescale 1ns/1ps
module bus_arb_node_tb_top;
  localparam int N = 6;
  localparam int IW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IW-1:0] node_id = IW'(2);
  logic acc_req = 1'b0, acc_done = 1'b0;
  logic [N-1:0] req_lines = '0;
  logic bus_req, stall, drive_en;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  bus_arb_node #(.NUM_NODES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .node_id(node_id), .acc_req(acc_req),
    .acc_done(acc_done), .req_lines(req_lines), .bus_req(bus_req),
    .stall(stall), .drive_en(drive_en));

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; acc_req = 1'b0; acc_done = 1'b0; req_lines = '0;
    repeat (3) step();
    #1;
    chk("R7 bus_req in reset", bus_req, 1'b0);
    chk("R7 drive_en in reset", drive_en, 1'b0);
    chk("R7 stall in reset", stall, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_basic();
    step(); acc_req = 1'b1; req_lines = 6'b000010; #1;
    chk("R1 request same cycle", bus_req, 1'b1);
    chk("R2 stall while waiting", stall, 1'b1);
    chk("R5 no drive before grant", drive_en, 1'b0);
    step(); #1;
    chk("R5 drive after idle grant", drive_en, 1'b1);
    chk("R2 stall released at grant", stall, 1'b0);
    acc_req = 1'b0; #1;
    chk("R6 line held without acc_req", bus_req, 1'b1);
    chk("R9 own bit ignored", drive_en, 1'b1);
    step(); #1;
    chk("R6 still driving", drive_en, 1'b1);
    acc_done = 1'b1; acc_req = 1'b1;
    step(); acc_done = 1'b0; #1;
    chk("R6 line low after done", bus_req, 1'b0);
    chk("R5 undriven in transition", drive_en, 1'b0);
    chk("R2 stall in release cycle", stall, 1'b1);
    step(); #1;
    chk("R1 request after release", bus_req, 1'b1);
    chk("R3 no owner after empty transition", drive_en, 1'b0);
    step(); #1;
    chk("R4 regain bus alone", drive_en, 1'b1);
    acc_req = 1'b0; acc_done = 1'b1;
    step(); acc_done = 1'b0; #1;
    chk("R6 released", bus_req, 1'b0);
    step();
  endtask

  task automatic t_priority();
    req_lines = 6'b001000;
    step(); acc_req = 1'b1; req_lines = 6'b001101; #1;
    chk("R2 stall behind owner 4", stall, 1'b1);
    step(); #1;
    chk("R3 owner holds while line high", stall, 1'b1);
    req_lines = 6'b000101;
    step(); #1;
    chk("R4 node 1 beats node 2", stall, 1'b1);
    chk("R8 waiter keeps line", bus_req, 1'b1);
    step(); #1;
    chk("R3 node 1 keeps bus", drive_en, 1'b0);
    req_lines = 6'b000100;
    step(); #1;
    chk("R4 node 2 beats node 3", drive_en, 1'b1);
    chk("R2 no stall on grant", stall, 1'b0);
    acc_req = 1'b0; acc_done = 1'b1;
    step(); acc_done = 1'b0; #1;
    chk("R5 undriven at handover", drive_en, 1'b0);
    step(); #1;
    chk("R3 node 3 took bus", drive_en, 1'b0);
    req_lines = '0;
    step(); step();
  endtask

  task automatic t_reset_default();
    do_reset();
    step(); acc_req = 1'b1; req_lines = 6'b000001; #1;
    chk("R8 request raised", bus_req, 1'b1);
    step(); #1;
    chk("R7 node 1 default owner", stall, 1'b1);
    req_lines = 6'b000000;
    step(); #1;
    chk("R4 node 2 after node 1", drive_en, 1'b1);
    acc_req = 1'b0; acc_done = 1'b1;
    step(); acc_done = 1'b0;
    step();
  endtask

  initial begin
    do_reset();
    t_basic();
    t_priority();
    t_reset_default();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule